// File: doc/BRIEF.md
# GPIO Port Controller

A register-mapped general-purpose I/O block serving up to 32 ports, with the number of ports set by the `NUM_PORTS` parameter (24 by default; 14 or 32 are typical alternatives). Software reaches it through a simple APB-style slave port. Each port has its own configuration word. That word selects whether the output register reaches the pad, whether the input is visible, whether the output buffer drives, and whether interrupts are enabled. It also holds a 3-bit detection mode. Towards the pads the block presents `pad_out`, `pad_oe` and `pad_in` per port. Every port has its own interrupt line.

Software can write one port's configuration, or one value to every port at once, or one value to a group of eight ports. Output bits can be loaded as a whole word. They can also be set or cleared through masks, so no read-modify-write is needed. Pin inputs are synchronised before use. Detected events latch into a sticky pending register, which software clears by writing ones. The bus has no back-pressure: `pready` is always high, so every access completes in its access phase.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all configuration words, the output register and the pending register are zero, and `pad_out`, `pad_oe` and `irq_o` are all low.
- R2: The configuration word for port p sits at byte offset 4p. Its fields are: bit 0 routes the output register to the pad, bit 1 makes the input visible, bit 2 enables the output buffer, bit 3 enables interrupts, and bits [7:5] select the detection mode. Bit 4 and bits [31:8] read back as zero. Words for ports at or above `NUM_PORTS` ignore writes and read zero.
- R3: A write to 0x8C loads the written configuration into every port. A write to 0x90+4n loads it into ports 8n to 8n+7, skipping any that do not exist.
- R4: `pad_oe[p]` equals configuration bit 2 of port p, and `pad_out[p]` equals output bit p AND configuration bit 0. With code 0x2 the port is input only, with 0x5 it is output only, and with 0x3 it is bidirectional with the pad released. With 0x7 it is bidirectional and driving, and the input stays readable.
- R5: The output register at 0x88 is written and read as a whole word, with bit p mapped to port p. Bits at or above `NUM_PORTS` read zero.
- R6: A write to 0xA4 ORs the written mask into the output register. A write to 0xA0 clears the masked bits. Other bits keep their values.
- R7: The input register at 0x84 returns `pad_in` after a two-flop synchroniser, ANDed per port with configuration bit 1. Writes to it have no effect.
- R8: Mode 0 flags a port while its synchronised input is high. Mode 1 flags it while the input is low.
- R9: Mode 2 flags a rising edge, mode 3 a falling edge and mode 4 either edge. An edge on `pad_in` placed just after a clock edge shows on `irq_o` after the third following clock edge, and not after the second.
- R10: Pending bits at 0x80 are sticky until software writes a one to them. A clear wins over an event in the same cycle. A level condition that still holds sets the bit again one cycle later.
- R11: A pending bit can only be set while configuration bits 1 and 3 are both set, so output-only ports never set it. `irq_o[p]` is pending bit p AND configuration bit 3.
- R12: Mode values 5, 6 and 7 never set a pending bit.
- R13: A write takes effect at the access phase (`psel` and `penable` both high). `prdata` is valid during a read access phase, `pready` is always high, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in a read access phase |
| pready | output | 1 | Always high |
| pad_in | input | NUM_PORTS | Pin input values |
| pad_out | output | NUM_PORTS | Pin output values |
| pad_oe | output | NUM_PORTS | Pin output-buffer enables |
| irq_o | output | NUM_PORTS | Per-port interrupt lines |

## Verification
A corrupted configuration word shows up on `pad_oe` or `pad_out` immediately after the write that caused it, and also on the next readback. A wrong output register shows on the pads in the same way. A fault in the synchroniser or edge history changes the cycle in which `irq_o` rises. That is pinned to the third clock edge after a pin change. A pending bit that fails to hold or fails to clear shows up on `irq_o` and in the pending register at the next read. The bench reads that register within a few cycles of every clear.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int REG_ADDR_W = 8;
  localparam int DATA_W     = 32;
  localparam int MAX_PORTS  = 32;

  // word indices (byte offset / 4)
  localparam logic [5:0] W_PEND = 6'h20;
  localparam logic [5:0] W_IN   = 6'h21;
  localparam logic [5:0] W_OUT  = 6'h22;
  localparam logic [5:0] W_ALL  = 6'h23;
  localparam logic [5:0] W_GRP0 = 6'h24;
  localparam logic [5:0] W_CLR  = 6'h28;
  localparam logic [5:0] W_SET  = 6'h29;

  typedef enum logic [2:0] {
    DET_LVL_HI = 3'd0,
    DET_LVL_LO = 3'd1,
    DET_RISE   = 3'd2,
    DET_FALL   = 3'd3,
    DET_BOTH   = 3'd4
  } det_mode_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       irq_en;
    logic       buf_en;
    logic       in_en;
    logic       out_en;
  } port_cfg_t;

  function automatic port_cfg_t word2cfg(logic [DATA_W-1:0] w);
    port_cfg_t c;
    c.mode   = w[7:5];
    c.irq_en = w[3];
    c.buf_en = w[2];
    c.in_en  = w[1];
    c.out_en = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg2word(port_cfg_t c);
    return {24'd0, c.mode, 1'b0, c.irq_en, c.buf_en, c.in_en, c.out_en};
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur = s2_q;
  assign prv = s3_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cfg_t cfg,
  input  logic      cur,
  input  logic      prv,
  input  logic      clr,
  output logic      pend,
  output logic      irq
);
  logic hit, armed, pend_q;

  always_comb begin
    case (cfg.mode)
      DET_LVL_HI: hit = cur;
      DET_LVL_LO: hit = ~cur;
      DET_RISE:   hit = cur & ~prv;
      DET_FALL:   hit = ~cur & prv;
      DET_BOTH:   hit = cur ^ prv;
      default:    hit = 1'b0;
    endcase
  end

  assign armed = cfg.in_en & cfg.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (clr) pend_q <= 1'b0;
    else          pend_q <= pend_q | (armed & hit);
  end

  assign pend = pend_q;
  assign irq  = pend_q & cfg.irq_en;

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);
  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q);
  // R11
  pend_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pend_q) |=> !pend_q);
  // R12
  pend_badmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.mode > 3'd4) && !pend_q) |=> !pend_q);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [REG_ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  input  logic [NUM_PORTS-1:0]  pad_in,
  output logic [NUM_PORTS-1:0]  pad_out,
  output logic [NUM_PORTS-1:0]  pad_oe,
  output logic [NUM_PORTS-1:0]  irq_o
);
  localparam int IDX_W = REG_ADDR_W - 2;

  logic             wr_acc, rd_acc;
  logic [IDX_W-1:0] widx;
  logic [NUM_PORTS-1:0] out_q, in_cur, in_prv, in_vis, pend_v, clr_v;
  logic [NUM_PORTS-1:0] wmask;
  port_cfg_t        cfg_q [NUM_PORTS];
  logic             unused_bits;

  assign wr_acc = psel & penable & pwrite;
  assign rd_acc = psel & penable & ~pwrite;
  assign widx   = paddr[REG_ADDR_W-1:2];
  assign wmask  = pwdata[NUM_PORTS-1:0];
  assign pready = 1'b1;
  assign unused_bits = ^{pwdata, paddr[1:0]};

  gpio_in_sync #(.W(NUM_PORTS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .cur(in_cur), .prv(in_prv)
  );

  assign clr_v = (wr_acc && widx == W_PEND) ? wmask : '0;

  // output register: whole-word load, set mask, clear mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (wr_acc) begin
      case (widx)
        W_OUT:   out_q <= wmask;
        W_SET:   out_q <= out_q | wmask;
        W_CLR:   out_q <= out_q & ~wmask;
        default: out_q <= out_q;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [5:0] OWN_IDX = 6'(p);
    localparam logic [5:0] GRP_IDX = W_GRP0 + 6'(p / 8);
    logic hit_me;

    assign hit_me = wr_acc && (widx == OWN_IDX || widx == W_ALL || widx == GRP_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[p] <= '0;
      else if (hit_me) cfg_q[p] <= word2cfg(pwdata);
    end

    assign pad_out[p] = out_q[p] & cfg_q[p].out_en;
    assign pad_oe[p]  = cfg_q[p].buf_en;
    assign in_vis[p]  = in_cur[p] & cfg_q[p].in_en;

    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[p]),
      .cur(in_cur[p]), .prv(in_prv[p]), .clr(clr_v[p]),
      .pend(pend_v[p]), .irq(irq_o[p])
    );
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      for (int k = 0; k < NUM_PORTS; k++)
        if (widx == 6'(k)) prdata = cfg2word(cfg_q[k]);
      case (widx)
        W_PEND:  prdata[NUM_PORTS-1:0] = pend_v;
        W_IN:    prdata[NUM_PORTS-1:0] = in_vis;
        W_OUT:   prdata[NUM_PORTS-1:0] = out_q;
        default: ;
      endcase
    end
  end

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && widx == W_SET) |=> ((out_q & $past(wmask)) == $past(wmask)));
  // R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && widx == W_CLR) |=> ((out_q & $past(wmask)) == '0));
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  localparam int N = 24;
  localparam logic [31:0] PMASK = 32'((64'd1 << N) - 1);

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe, irq_o;

  int n_chk = 0, n_bad = 0;
  logic done = 0;
  logic [7:0]  m_cfg [32];
  logic [31:0] m_out;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.NUM_PORTS(N)) i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(negedge clk); d = prdata;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] cfg_word(int p);
    return (p < N) ? {24'd0, m_cfg[p] & 8'hEF} : 32'd0;
  endfunction

  function automatic logic [31:0] exp_pad_out();
    logic [31:0] r = 0;
    for (int i = 0; i < N; i++) r[i] = m_out[i] & m_cfg[i][0];
    return r;
  endfunction

  function automatic logic [31:0] exp_pad_oe();
    logic [31:0] r = 0;
    for (int i = 0; i < N; i++) r[i] = m_cfg[i][2];
    return r;
  endfunction

  task automatic pend_bit(string req, int p, logic exp);
    logic [31:0] d;
    apb_rd(8'h80, d);
    chk(req, {31'd0, d[p]}, {31'd0, exp});
  endtask

  task automatic clear_all();
    apb_wr(8'h80, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_cfg[i] = 0;
    m_out = 0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);

    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    apb_rd(8'h00, d); chk("R1 cfg0", d, 0);
    apb_rd(8'h88, d); chk("R1 out", d, 0);
    apb_rd(8'h80, d); chk("R1 pend", d, 0);

    // random register traffic: R2 R3 R4 R5 R6
    for (int it = 0; it < 200; it++) begin
      int op = int'($urandom % 6);
      logic [31:0] w = $urandom;
      case (op)
        0: begin
          int p = int'($urandom % 32);
          apb_wr(8'(p * 4), w);
          if (p < N) m_cfg[p] = w[7:0];
        end
        1: begin
          apb_wr(8'h8C, w);
          for (int i = 0; i < N; i++) m_cfg[i] = w[7:0];
        end
        2: begin
          int g = int'($urandom % 4);
          apb_wr(8'(8'h90 + 4 * g), w);
          for (int i = 8 * g; i < 8 * g + 8; i++) if (i < N) m_cfg[i] = w[7:0];
        end
        3: begin apb_wr(8'h88, w); m_out = w & PMASK; end
        4: begin apb_wr(8'hA4, w); m_out = m_out | (w & PMASK); end
        default: begin apb_wr(8'hA0, w); m_out = m_out & ~w; end
      endcase
      chk("R4 pad_out", 32'(pad_out), exp_pad_out());
      chk("R4 pad_oe", 32'(pad_oe), exp_pad_oe());
      if (it % 3 == 0) begin
        int p = int'($urandom % 32);
        apb_rd(8'(p * 4), d); chk("R2/R3 cfg readback", d, cfg_word(p));
        apb_rd(8'h88, d); chk("R5/R6 out readback", d, m_out);
      end
    end

    // R2 bit 4 reads zero, absent port ignores writes
    apb_wr(8'h04, 32'hFFFF_FFFF); m_cfg[1] = 8'hFF;
    apb_rd(8'h04, d); chk("R2 bit4 zero", d, 32'h0000_00EF);
    apb_wr(8'(30 * 4), 32'h0000_00FF);
    apb_rd(8'(30 * 4), d); chk("R2 absent port", d, 0);
    // R3 byte groups
    apb_wr(8'h8C, 32'h0); for (int i = 0; i < N; i++) m_cfg[i] = 0;
    apb_wr(8'h98, 32'h0000_0005);
    apb_rd(8'(15 * 4), d); chk("R3 group2 skips port15", d, 0);
    apb_rd(8'(16 * 4), d); chk("R3 group2 port16", d, 32'h5);
    apb_rd(8'(23 * 4), d); chk("R3 group2 port23", d, 32'h5);
    apb_wr(8'h9C, 32'h0000_0007);
    apb_rd(8'(23 * 4), d); chk("R3 group3 absent", d, 32'h5);
    // R5 high bits
    apb_wr(8'h88, 32'hFFFF_FFFF);
    apb_rd(8'h88, d); chk("R5 out width", d, PMASK);
    // R6 set/clear
    apb_wr(8'hA0, 32'h0000_F0F0);
    apb_rd(8'h88, d); chk("R6 clear", d, PMASK & ~32'h0000_F0F0);
    apb_wr(8'h88, 32'h0);
    apb_wr(8'hA4, 32'h0001_0001);
    apb_rd(8'h88, d); chk("R6 set", d, 32'h0001_0001);

    // R4 direction codes on port 0 (out bit 0 = 1)
    apb_wr(8'h00, 32'h5);
    chk("R4 output only oe", {31'd0, pad_oe[0]}, 1);
    chk("R4 output only out", {31'd0, pad_out[0]}, 1);
    apb_wr(8'h00, 32'h2);
    chk("R4 input only oe", {31'd0, pad_oe[0]}, 0);
    chk("R4 input only out", {31'd0, pad_out[0]}, 0);
    apb_wr(8'h00, 32'h3); pad_in[0] = 1'b1; wait_clk(4);
    chk("R4 bidir released oe", {31'd0, pad_oe[0]}, 0);
    apb_rd(8'h84, d); chk("R4 bidir input readable", {31'd0, d[0]}, 1);
    apb_wr(8'h00, 32'h7);
    chk("R4 bidir drive oe", {31'd0, pad_oe[0]}, 1);
    chk("R4 bidir drive out", {31'd0, pad_out[0]}, 1);
    apb_rd(8'h84, d); chk("R4 bidir drive input", {31'd0, d[0]}, 1);

    // R7 input register
    apb_wr(8'h8C, 32'h2);
    apb_wr(8'h98, 32'h5);
    pad_in = N'(32'hA5_3C96); wait_clk(4);
    apb_rd(8'h84, d); chk("R7 input mask", d, 32'h00_3C96);
    apb_wr(8'h84, 32'hFFFF_FFFF);
    apb_rd(8'h84, d); chk("R7 write ignored", d, 32'h00_3C96);

    // R13 unmapped, pready
    apb_rd(8'hB0, d); chk("R13 unmapped", d, 0);
    chk("R13 pready", {31'd0, pready}, 1);

    // interrupt section: all ports idle
    apb_wr(8'h8C, 32'h0);
    pad_in = '0; wait_clk(4); clear_all();
    chk("R11 no irq idle", 32'(irq_o), 0);

    // R9 latency, rising edge on port 5
    apb_wr(8'h14, 32'h4A);
    @(posedge clk); #1 pad_in[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 not after 2nd edge", {31'd0, irq_o[5]}, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 after 3rd edge", {31'd0, irq_o[5]}, 1);
    clear_all(); wait_clk(5);
    pend_bit("R10 edge no retrigger", 5, 0);

    // R8/R10 level high port 3
    apb_wr(8'h0C, 32'h0A);
    pad_in[3] = 1'b1; wait_clk(5);
    pend_bit("R8 level high", 3, 1);
    chk("R11 irq level high", {31'd0, irq_o[3]}, 1);
    apb_wr(8'h80, 32'h8);
    pend_bit("R10 level re-set", 3, 1);
    pad_in[3] = 1'b0; wait_clk(5);
    pend_bit("R10 sticky", 3, 1);
    apb_wr(8'h80, 32'h8); wait_clk(2);
    pend_bit("R10 cleared", 3, 0);

    // R8 level low port 4
    apb_wr(8'h10, 32'h2A); wait_clk(2);
    pend_bit("R8 level low", 4, 1);
    pad_in[4] = 1'b1; wait_clk(4); apb_wr(8'h80, 32'h10); wait_clk(2);
    pend_bit("R8 level low gone", 4, 0);

    // R9 falling port 6
    apb_wr(8'h18, 32'h6A);
    pad_in[6] = 1'b1; wait_clk(5);
    pend_bit("R9 fall ignores rise", 6, 0);
    pad_in[6] = 1'b0; wait_clk(5);
    pend_bit("R9 fall", 6, 1);

    // R9 both edges port 7
    apb_wr(8'h1C, 32'h8A);
    pad_in[7] = 1'b1; wait_clk(5);
    pend_bit("R9 both rise", 7, 1);
    apb_wr(8'h80, 32'h80); wait_clk(3);
    pend_bit("R9 both quiet", 7, 0);
    pad_in[7] = 1'b0; wait_clk(5);
    pend_bit("R9 both fall", 7, 1);

    // R11 output only and input-disabled
    apb_wr(8'h20, 32'h0D);
    apb_wr(8'h24, 32'h02);
    pad_in[8] = 1'b1; pad_in[9] = 1'b1; wait_clk(5);
    pend_bit("R11 output only", 8, 0);
    pend_bit("R11 irq disabled", 9, 0);
    chk("R11 irq9 low", {31'd0, irq_o[9]}, 0);

    // R12 undefined modes
    for (int m = 5; m < 8; m++) begin
      apb_wr(8'h28, 32'(m << 5) | 32'h0A);
      pad_in[10] = 1'b1; wait_clk(4); pad_in[10] = 1'b0; wait_clk(4);
      pend_bit("R12 undefined mode", 10, 0);
    end

    // R11 irq masked while pending held
    apb_wr(8'h2C, 32'h0A);
    pad_in[11] = 1'b1; wait_clk(5);
    apb_wr(8'h2C, 32'h02);
    pend_bit("R11 pending kept", 11, 1);
    chk("R11 irq masked", {31'd0, irq_o[11]}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule